// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

This block runs one parallel section across a fixed group of thread control units (TCUs). A master asks for a section by raising a spawn request with a thread count. The dispatcher latches the count and sends it, together with the start of the section, to every unit on one shared broadcast path. Unit `i` begins on virtual thread `i`. Thread bodies are not modelled: a unit that is running reports the end of its current thread with a one-cycle done pulse.

When a thread ends, the unit draws its next thread ID from a shared fetch-and-add unit that works on one global counter. The counter is loaded with the number of units at spawn. If several units ask in the same cycle, the lower unit index receives the lower value. Each requester gets a distinct consecutive value, and the counter moves forward by the number of requests. A unit whose drawn ID is not below the thread count stops and never waits on another unit. When every unit has stopped, the dispatcher gives a one-cycle join pulse and is ready for the next spawn. A spawn request made during an active section is refused.

Thread IDs run from 0 to count-1.

Top module: `spawn_join_dispatch`

## Requirements
- R1: One cycle after a spawn request is accepted while idle, `busy` is high and every unit `i` with `i` below the count has `tcu_run[i]` high and reports ID `i`.
- R2: A unit whose index is not below the thread count never runs in that section. With a count of 0, no unit runs at all.
- R3: A running unit that pulses done receives, one cycle later, the next value of the global counter. The first value handed out in a section is the number of units.
- R4: When several running units pulse done in the same cycle, they receive consecutive values in ascending unit-index order, and the counter moves forward by the number of such units.
- R5: A unit whose newly drawn ID is equal to or greater than the thread count drops `tcu_run` in the next cycle and stays stopped for the rest of the section.
- R6: A done pulse on a unit that is not running has no effect. A running unit without a done pulse keeps its ID.
- R7: One cycle after all units have stopped, `join_pulse` is high for exactly one cycle, and `busy` is low in that same cycle.
- R8: A spawn request made while `busy` is high sets `spawn_reject` in the next cycle and changes neither the count nor the IDs handed out.
- R9: After reset the block is idle, with no unit running and no join. After a join, a new spawn is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spawn_valid | input | 1 | Spawn request from the master |
| spawn_count | input | ID_W | Number of virtual threads in the section |
| tcu_done | input | NUM_TCU | Per-unit pulse that ends the current thread |
| tcu_run | output | NUM_TCU | Unit is executing a thread |
| tcu_id | output | NUM_TCU*ID_W | Current thread ID of each unit, unit `i` in bits `[i*ID_W +: ID_W]` |
| busy | output | 1 | A section is active |
| join_pulse | output | 1 | One-cycle pulse at the end of the section |
| spawn_reject | output | 1 | The spawn request of the previous cycle was refused |

## Verification
Every thread count from 0 to three times the number of units is run under four done patterns. In the first, all units finish together, and the done pulses also reach units that are not running. This exposes the ordering within a batch and any effect of done on stopped units. In the second and third, only the lowest or only the highest running unit finishes. These show whether the counter hands out values one at a time, whatever the requester's index. The fourth alternates between even and odd units, which mixes batch requests and single requests. Counts below the number of units check that the high-index units stop at once. During one pattern a spawn is sent while the section is still active, to confirm that it is refused and has no side effect.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/fa_unit.sv
module fa_unit #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]        req,
    input  logic [W-1:0]        base,
    output logic [N-1:0][W-1:0] grant,
    output logic [W-1:0]        next_base
);
    // Requests are ranked by index. Each requester gets base plus the
    // number of lower-index requesters.
    always_comb begin
        logic [W-1:0] acc;
        acc = base;
        for (int i = 0; i < N; i++) begin
            grant[i] = acc;
            if (req[i]) acc = acc + W'(1);
        end
        next_base = acc;
    end
endmodule

// File: rtl/tcu_slot.sv
module tcu_slot #(
    parameter int IDX  = 0,
    parameter int ID_W = 8,
    parameter int GR_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [GR_W-1:0] bcast_count,
    input  logic            done,
    input  logic [GR_W-1:0] grant,
    output logic            req,
    output logic            run,
    output logic [ID_W-1:0] id
);
    typedef struct packed {
        logic            run;
        logic [GR_W-1:0] id;
    } slot_s;

    slot_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        req = s_q.run & done;
        if (start) begin
            s_d.run = (GR_W'(IDX) < bcast_count);
            s_d.id  = GR_W'(IDX);
        end else if (req) begin
            if (grant >= bcast_count) begin
                s_d.run = 1'b0;
            end else begin
                s_d.id = grant;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run = s_q.run;
    assign id  = s_q.id[ID_W-1:0];

    // A running unit always holds an ID below the broadcast count.
    a_r5_below_count: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.id < bcast_count));

    // Without done, a running unit keeps both its run state and its ID.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !done && !start) |=> (s_q.run && $stable(s_q.id)));

    // A done pulse either stops the unit or moves it to a new ID.
    a_r3_new_id: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && done) |=> (!s_q.run || (s_q.id != $past(s_q.id))));
endmodule

// File: rtl/spawn_join_dispatch.sv
module spawn_join_dispatch
    import dispatch_pkg::*;
#(
    parameter int NUM_TCU = 4,
    parameter int ID_W    = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spawn_valid,
    input  logic [ID_W-1:0]           spawn_count,
    input  logic [NUM_TCU-1:0]        tcu_done,
    output logic [NUM_TCU-1:0]        tcu_run,
    output logic [NUM_TCU*ID_W-1:0]   tcu_id,
    output logic                      busy,
    output logic                      join_pulse,
    output logic                      spawn_reject
);
    localparam int GR_W = ID_W + 2;

    typedef struct packed {
        phase_e          phase;
        logic [GR_W-1:0] count;
        logic [GR_W-1:0] gr;
        logic            join_p;
        logic            reject;
    } ctl_s;

    ctl_s s_d, s_q;

    logic                           start;
    logic [GR_W-1:0]                bcast;
    logic [NUM_TCU-1:0]             req;
    logic [NUM_TCU-1:0][GR_W-1:0]   grant;
    logic [GR_W-1:0]                gr_next;

    assign start = spawn_valid && (s_q.phase == PH_IDLE);
    assign bcast = start ? GR_W'(spawn_count) : s_q.count;

    fa_unit #(.N(NUM_TCU), .W(GR_W)) u_fa (
        .req       (req),
        .base      (s_q.gr),
        .grant     (grant),
        .next_base (gr_next)
    );

    for (genvar g = 0; g < NUM_TCU; g++) begin : g_slot
        tcu_slot #(.IDX(g), .ID_W(ID_W), .GR_W(GR_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (start),
            .bcast_count (bcast),
            .done        (tcu_done[g]),
            .grant       (grant[g]),
            .req         (req[g]),
            .run         (tcu_run[g]),
            .id          (tcu_id[g*ID_W +: ID_W])
        );
    end

    always_comb begin
        s_d        = s_q;
        s_d.join_p = 1'b0;
        s_d.reject = spawn_valid && (s_q.phase == PH_RUN);
        case (s_q.phase)
            PH_IDLE: begin
                if (spawn_valid) begin
                    s_d.phase = PH_RUN;
                    s_d.count = GR_W'(spawn_count);
                    s_d.gr    = GR_W'(NUM_TCU);
                end
            end
            default: begin
                s_d.gr = gr_next;
                if (tcu_run == '0) begin
                    s_d.phase  = PH_IDLE;
                    s_d.join_p = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy         = (s_q.phase == PH_RUN);
    assign join_pulse   = s_q.join_p;
    assign spawn_reject = s_q.reject;

    a_r7_join_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.join_p |=> !s_q.join_p);

    a_r7_join_all_retired: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.join_p |-> (tcu_run == '0 && s_q.phase == PH_IDLE));

    a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (spawn_valid && busy) |=> (spawn_reject && $stable(s_q.count)));

    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (s_q.gr == $past(s_q.gr) + GR_W'($past($countones(req)))));

    a_r2_idle_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tcu_run == '0));
endmodule

// File: tb/spawn_join_dispatch_test.sv
module spawn_join_dispatch_test;
    localparam int NT = 4;
    localparam int IW = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             spawn_valid = 1'b0;
    logic [IW-1:0]    spawn_count = '0;
    logic [NT-1:0]    tcu_done = '0;
    logic [NT-1:0]    tcu_run;
    logic [NT*IW-1:0] tcu_id;
    logic             busy, join_pulse, spawn_reject;

    always #10 clk = ~clk;

    spawn_join_dispatch #(.NUM_TCU(NT), .ID_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid),
        .spawn_count(spawn_count), .tcu_done(tcu_done), .tcu_run(tcu_run),
        .tcu_id(tcu_id), .busy(busy), .join_pulse(join_pulse),
        .spawn_reject(spawn_reject)
    );

    int tests = 0;
    int fails = 0;
    int erun [NT];
    int eid  [NT];
    int egr;
    int en;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string run_tag, input string id_tag);
        for (int i = 0; i < NT; i++) begin
            chk(int'(tcu_run[i]) == erun[i], run_tag, int'(tcu_run[i]), erun[i]);
            if (erun[i] != 0)
                chk(int'(tcu_id[i*IW +: IW]) == eid[i], id_tag,
                    int'(tcu_id[i*IW +: IW]), eid[i]);
        end
    endtask

    task automatic apply(input logic [NT-1:0] dm);
        int k;
        int nreq;
        tcu_done = dm;
        @(posedge clk);
        @(negedge clk);
        tcu_done = '0;
        k = egr;
        nreq = 0;
        for (int i = 0; i < NT; i++) begin
            if (erun[i] != 0 && dm[i]) begin
                if (k >= en) erun[i] = 0;
                else         eid[i] = k;
                k++;
                nreq++;
            end
        end
        egr = k;
        // Several fetches in one cycle fall under R4, a single one under R3.
        // Run-state checks cover retirement (R5) and ignored pulses (R6).
        if (nreq > 1) check_state("R5/R6", "R4");
        else          check_state("R5/R6", "R3");
    endtask

    task automatic section(input int n, input int pat);
        int iter;
        logic [NT-1:0] m;
        logic [NT-1:0] live;
        spawn_valid = 1'b1;
        spawn_count = IW'(n);
        @(posedge clk);
        @(negedge clk);
        spawn_valid = 1'b0;
        en  = n;
        egr = NT;
        for (int i = 0; i < NT; i++) begin
            erun[i] = (i < n) ? 1 : 0;
            eid[i]  = i;
        end
        chk(busy == 1'b1, "R1", int'(busy), 1);
        check_state((n < NT) ? "R2" : "R1", "R1");
        iter = 0;
        live = '1;
        while (live != '0 && iter < 200) begin
            live = '0;
            for (int i = 0; i < NT; i++) live[i] = (erun[i] != 0);
            if (live == '0) break;
            m = '0;
            case (pat)
                0: m = '1;
                1: begin
                    for (int i = NT - 1; i >= 0; i--) if (live[i]) m = NT'(1) << i;
                end
                2: begin
                    for (int i = 0; i < NT; i++) if (live[i]) m = NT'(1) << i;
                end
                default: m = (iter % 2 == 1) ? NT'('h5) : NT'('hA);
            endcase
            if (pat == 1 && iter == 1) begin
                spawn_valid = 1'b1;
                spawn_count = IW'(1);
            end
            apply(m);
            if (pat == 1 && iter == 1) begin
                spawn_valid = 1'b0;
                chk(spawn_reject == 1'b1, "R8", int'(spawn_reject), 1);
            end
            iter++;
        end
        @(posedge clk);
        @(negedge clk);
        chk(join_pulse == 1'b1, "R7", int'(join_pulse), 1);
        chk(busy == 1'b0, "R7", int'(busy), 0);
        @(posedge clk);
        @(negedge clk);
        chk(join_pulse == 1'b0, "R7", int'(join_pulse), 0);
        chk(spawn_reject == 1'b0, "R8", int'(spawn_reject), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9", int'(busy), 0);
        chk(tcu_run == '0, "R9", int'(tcu_run), 0);
        chk(join_pulse == 1'b0, "R9", int'(join_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9", int'(busy), 0);
        for (int n = 0; n <= 3 * NT; n++) begin
            for (int p = 0; p < 4; p++) begin
                section(n, p);
            end
        end
        // R9: a new spawn is accepted directly after the join cycle of the last section.
        section(2, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule